// File: doc/BRIEF.md
# Burst Column Sequencer

This block produces the column address for each beat of a synchronous DRAM burst. The command logic pulses a start strobe and supplies a starting column, a length code and an ordering bit. The sequencer then holds a beat counter and shows the column for the current beat. The ordering bit chooses between a plain incrementing order and an XOR order. In both orders the column wraps inside the block of columns aligned to the burst length, and the upper column bits stay fixed.

A per-cycle advance enable decides whether the data path consumed the current beat. A low advance enable holds the burst in place. A terminate strobe ends the burst in progress, and the beat that coincides with it is not presented as valid. In page mode the column runs through every column of the row, wrapping as it goes. The burst then continues until it is terminated or restarted, and no last-beat flag is raised for it.

Top module: `col_burst_gen`

## Requirements
- R1: While reset is asserted and after reset is released, `beat_vld_o` and `last_o` are 0 until the first start.
- R2: `start_i` is sampled at a rising clock edge. From that edge, `beat_vld_o` is 1 (unless `term_i` is high) and `col_o` equals the sampled `start_col_i`. The length code and ordering bit are captured at the same edge, and later changes on `len_code_i` and `ilv_i` do not affect the running burst.
- R3: Length code (3 bits): 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 selects page mode. The codes 100, 101 and 110 behave as a length of 1.
- R4: With `ilv_i`=0 and length N, the column of beat k keeps the start column bits at and above log2(N). Its low log2(N) bits equal (start low bits + k) mod N.
- R5: With `ilv_i`=1 and length N, the low log2(N) bits of beat k equal the start low bits XOR k, and the upper bits are unchanged.
- R6: In a fixed-length burst, `last_o` is 1 exactly on beat N-1. Advancing past that beat ends the burst, so `beat_vld_o` is 0 after that edge.
- R7: In page mode, beat k shows (start + k) mod 2^COL_W whatever the value of `ilv_i`. `last_o` stays 0, and the burst wraps past the top column and keeps going.
- R8: While `adv_i` is 0, the column and the beat position hold, and `beat_vld_o` stays 1.
- R9: In a cycle where `term_i` is 1, `beat_vld_o` and `last_o` are 0. After that edge the burst is over. If `start_i` and `term_i` are both 1, the start wins.
- R10: A start during a running burst abandons the old burst and begins the new one at its own column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst at this edge |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 selects XOR ordering |
| adv_i | input | 1 | Current beat consumed at this edge |
| term_i | input | 1 | End the burst in progress |
| col_o | output | COL_W | Column of the current beat |
| beat_vld_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The hardest case to reach is the page-mode wrap. It needs a burst that starts near the top column and advances for more beats than the row holds. Only then can the bench see the column roll over to zero while `last_o` stays low and the ordering bit is set and ignored. The bench starts at column 0xF0 with XOR ordering requested and advances 300 beats, comparing every column. It then terminates the burst. Separate scenarios stall the burst in the middle of a fixed-length run, and raise the terminate and start strobes together.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;

   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      LEN_ONE   = 3'b000,
      LEN_TWO   = 3'b001,
      LEN_FOUR  = 3'b010,
      LEN_EIGHT = 3'b011,
      LEN_PAGE  = 3'b111
   } len_code_e;

endpackage

// File: rtl/cbg_len_decode.sv
module cbg_len_decode
   import col_burst_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [COL_W-1:0]  span_mask_o,
   output logic              page_o
);

   always_comb begin
      page_o      = 1'b0;
      span_mask_o = '0;
      case (code_i)
         LEN_TWO:   span_mask_o = COL_W'(1);
         LEN_FOUR:  span_mask_o = COL_W'(3);
         LEN_EIGHT: span_mask_o = COL_W'(7);
         LEN_PAGE: begin
            span_mask_o = '1;
            page_o      = 1'b1;
         end
         default:   span_mask_o = '0;
      endcase
   end

endmodule

// File: rtl/cbg_beat_counter.sv
module cbg_beat_counter #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             adv_i,
   input  logic             term_i,
   input  logic [COL_W-1:0] span_mask_i,
   input  logic             page_i,
   output logic             active_o,
   output logic [COL_W-1:0] beat_o,
   output logic             at_end_o
);

   logic             active_q;
   logic [COL_W-1:0] beat_q;

   assign at_end_o = !page_i && (beat_q == span_mask_i);
   assign active_o = active_q;
   assign beat_o   = beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         beat_q   <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         beat_q   <= '0;
      end else if (active_q) begin
         if (term_i) begin
            active_q <= 1'b0;
         end else if (adv_i) begin
            if (at_end_o) active_q <= 1'b0;
            else          beat_q   <= beat_q + 1'b1;
         end
      end
   end

   // R8
   adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !adv_i && !term_i && !start_i) |=> (active_q && $stable(beat_q)));

   // R6
   end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && adv_i && at_end_o && !term_i && !start_i) |=> !active_q);

endmodule

// File: rtl/cbg_col_map.sv
module cbg_col_map #(
   parameter int COL_W  = 8,
   parameter bit ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] span_mask_i,
   input  logic             page_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] offset;

   generate
      if (ILV_EN) begin : g_ilv
         always_comb begin
            if (ilv_i && !page_i) offset = base_i ^ beat_i;
            else                  offset = base_i + beat_i;
         end
      end else begin : g_seq_only
         logic unused_ilv;
         assign unused_ilv = ilv_i ^ page_i;
         always_comb offset = base_i + beat_i;
      end
   endgenerate

   assign col_o = (base_i & ~span_mask_i) | (offset & span_mask_i);

endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen
   import col_burst_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter bit ILV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [COL_W-1:0]  start_col_i,
   input  logic [CODE_W-1:0] len_code_i,
   input  logic              ilv_i,
   input  logic              adv_i,
   input  logic              term_i,
   output logic [COL_W-1:0]  col_o,
   output logic              beat_vld_o,
   output logic              last_o
);

   localparam int MIN_COL_W = 3;
   localparam int MAX_COL_W = 16;

   generate
      if (COL_W < MIN_COL_W || COL_W > MAX_COL_W) begin : g_bad_width
         $error("col_burst_gen: COL_W out of range");
      end
   endgenerate

   logic [COL_W-1:0]  base_q;
   logic [CODE_W-1:0] code_q;
   logic              ilv_q;
   logic [COL_W-1:0]  span_mask;
   logic              page;
   logic              active;
   logic [COL_W-1:0]  beat;
   logic              at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         code_q <= LEN_ONE;
         ilv_q  <= 1'b0;
      end else if (start_i) begin
         base_q <= start_col_i;
         code_q <= len_code_i;
         ilv_q  <= ilv_i;
      end
   end

   cbg_len_decode #(.COL_W(COL_W)) u_dec (
      .code_i      (code_q),
      .span_mask_o (span_mask),
      .page_o      (page)
   );

   cbg_beat_counter #(.COL_W(COL_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .adv_i       (adv_i),
      .term_i      (term_i),
      .span_mask_i (span_mask),
      .page_i      (page),
      .active_o    (active),
      .beat_o      (beat),
      .at_end_o    (at_end)
   );

   cbg_col_map #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_map (
      .base_i      (base_q),
      .beat_i      (beat),
      .span_mask_i (span_mask),
      .page_i      (page),
      .ilv_i       (ilv_q),
      .col_o       (col_o)
   );

   assign beat_vld_o = active && !term_i;
   assign last_o     = beat_vld_o && at_end;

   // R2
   first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (col_o == $past(start_col_i)));

   // R9
   term_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (term_i && !start_i) |=> !beat_vld_o);

   // R7
   page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q == LEN_PAGE) |-> !last_o);

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!beat_vld_o && !last_o));

endmodule

// File: tb/col_burst_gen_bench.sv
module col_burst_gen_bench;

   localparam int COL_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       len_code_i = 3'b000;
   logic             ilv_i = 1'b0;
   logic             adv_i = 1'b0;
   logic             term_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             beat_vld_o;
   logic             last_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   col_burst_gen #(.COL_W(COL_W)) u_col_burst_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .ilv_i(ilv_i), .adv_i(adv_i), .term_i(term_i),
      .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic int len_of(input logic [2:0] code);
      case (code)
         3'b001: return 2;
         3'b010: return 4;
         3'b011: return 8;
         3'b111: return 256;
         default: return 1;
      endcase
   endfunction

   function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                          input bit ilv, input int k);
      int n;
      logic [7:0] m, lo;
      n = len_of(code);
      if (code == 3'b111) return 8'(s + k);
      m  = 8'(n - 1);
      lo = ilv ? (s ^ 8'(k)) : 8'(s + k);
      return (s & ~m) | (lo & m);
   endfunction

   task automatic begin_burst(input logic [7:0] s, input logic [2:0] code, input bit ilv);
      start_i = 1'b1; start_col_i = s; len_code_i = code; ilv_i = ilv; adv_i = 1'b0;
      tick();
      start_i = 1'b0; adv_i = 1'b1;
      #1;
   endtask

   task automatic t_fixed(input logic [7:0] s, input logic [2:0] code, input bit ilv,
                          input string req);
      int n;
      n = len_of(code);
      begin_burst(s, code, ilv);
      for (int k = 0; k < n; k++) begin
         chk(beat_vld_o == 1'b1, req, beat_vld_o, 1);
         chk(col_o == exp_col(s, code, ilv, k), req, col_o, exp_col(s, code, ilv, k));
         // R6
         chk(last_o == (k == n - 1), "R6", last_o, (k == n - 1));
         tick();
         #1;
      end
      chk(beat_vld_o == 1'b0, "R6 end", beat_vld_o, 0);
      adv_i = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tick(); tick();
      // R1
      chk(beat_vld_o == 1'b0 && last_o == 1'b0, "R1", {beat_vld_o, last_o}, 0);
      rst_n = 1'b1;
      tick();
      chk(beat_vld_o == 1'b0, "R1 after", beat_vld_o, 0);
   endtask

   task automatic t_page();
      begin_burst(8'hF0, 3'b111, 1'b1);
      for (int k = 0; k < 300; k++) begin
         // R7
         chk(col_o == exp_col(8'hF0, 3'b111, 1'b1, k) && beat_vld_o, "R7",
             col_o, exp_col(8'hF0, 3'b111, 1'b1, k));
         chk(last_o == 1'b0, "R7 last", last_o, 0);
         tick();
         #1;
      end
      term_i = 1'b1;
      #1;
      // R9
      chk(beat_vld_o == 1'b0, "R9 page term", beat_vld_o, 0);
      tick();
      term_i = 1'b0;
      #1;
      chk(beat_vld_o == 1'b0, "R9 page over", beat_vld_o, 0);
      adv_i = 1'b0;
   endtask

   task automatic t_freeze();
      begin_burst(8'h10, 3'b011, 1'b0);
      tick(); tick();
      adv_i = 1'b0;
      #1;
      for (int k = 0; k < 3; k++) begin
         // R8
         chk(col_o == 8'h12 && beat_vld_o, "R8", col_o, 8'h12);
         tick();
         #1;
      end
      adv_i = 1'b1;
      tick();
      #1;
      chk(col_o == 8'h13, "R8 resume", col_o, 8'h13);
      adv_i = 1'b0;
      term_i = 1'b1;
      tick();
      term_i = 1'b0;
   endtask

   task automatic t_term();
      begin_burst(8'h40, 3'b010, 1'b0);
      tick(); tick(); tick();
      #1;
      chk(last_o == 1'b1, "R6 pre-term", last_o, 1);
      term_i = 1'b1;
      #1;
      // R9
      chk(beat_vld_o == 1'b0 && last_o == 1'b0, "R9 same cycle", {beat_vld_o, last_o}, 0);
      tick();
      term_i = 1'b0;
      #1;
      chk(beat_vld_o == 1'b0, "R9 after", beat_vld_o, 0);
      adv_i = 1'b0;
   endtask

   task automatic t_restart();
      begin_burst(8'h20, 3'b011, 1'b0);
      tick();
      start_i = 1'b1; start_col_i = 8'h85; len_code_i = 3'b010; ilv_i = 1'b1;
      term_i = 1'b1;
      tick();
      start_i = 1'b0; term_i = 1'b0;
      #1;
      // R10
      chk(beat_vld_o && col_o == 8'h85, "R10 restart", col_o, 8'h85);
      tick();
      #1;
      chk(col_o == 8'h84, "R10 new order", col_o, 8'h84);
      term_i = 1'b1;
      tick();
      term_i = 1'b0;
      adv_i = 1'b0;
   endtask

   task automatic t_mode_change();
      begin_burst(8'h3A, 3'b010, 1'b0);
      len_code_i = 3'b111; ilv_i = 1'b1;
      for (int k = 0; k < 4; k++) begin
         // R2
         chk(col_o == exp_col(8'h3A, 3'b010, 1'b0, k), "R2 mode latch",
             col_o, exp_col(8'h3A, 3'b010, 1'b0, k));
         tick();
         #1;
      end
      chk(beat_vld_o == 1'b0, "R2 length latched", beat_vld_o, 0);
      adv_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      finish_run();
   end

   initial begin
      t_reset();
      t_fixed(8'h2E, 3'b010, 1'b0, "R4 seq4");
      t_fixed(8'h07, 3'b011, 1'b0, "R4 seq8");
      t_fixed(8'h5B, 3'b011, 1'b1, "R5 ilv8");
      t_fixed(8'hA6, 3'b010, 1'b1, "R5 ilv4");
      t_fixed(8'h13, 3'b001, 1'b0, "R3 len2");
      t_fixed(8'h77, 3'b000, 1'b0, "R3 len1");
      t_fixed(8'h77, 3'b101, 1'b1, "R3 reserved");
      t_fixed(8'h77, 3'b110, 1'b0, "R3 reserved");
      t_page();
      t_freeze();
      t_term();
      t_restart();
      t_mode_change();
      finish_run();
   end

endmodule